// File: doc/BRIEF.md
# Low-power mode entry controller

This block is the power-management sequencer of a small microcontroller. When the core issues a wait-for-interrupt strobe it picks one of three low-power states: light sleep, power-down or deep power-down. The choice depends on the core's deep-sleep flag, a two-bit mode field and a lock bit in its control register. It then drives the clock and power enables of the core and peripheral domains, the pin tri-state enable and the system reset request. It also sequences the return to the running state.

Light sleep stops only the core clock. Power-down stops all clocks but keeps the domains powered, and it wakes on a small set of qualified sources. Deep power-down removes every clock and power enable and tri-states the functional pins. It leaves only the external wake pin logic and a bank of retention registers alive, and it ends with a full system reset once a synchronised falling edge is seen on the wake pin. A two-bit exit code survives that reset so that software can tell which state it came back from. On any return from the two deeper states a one-cycle pulse forces the main clock back to the internal RC oscillator.

Top module: `lpm_ctrl`

## Requirements
- R1: A `wfi` pulse in the running state with `deep_sleep`=0 enters light sleep on the next cycle: `core_clk_en`=0, `periph_clk_en`=1, both power enables 1, `pin_tristate`=0. In light sleep `irq_any`=1 returns to running on the next cycle.
- R2: A `wfi` pulse with `deep_sleep`=1, mode field (control register bits [1:0]) = 3 and lock bit (bit 3) = 0 enters deep power-down: all four clock and power enables 0 and `pin_tristate`=1.
- R3: With the lock bit (bit 3) set, the same request with mode field 3 falls back to power-down instead of deep power-down.
- R4: A `wfi` pulse with `deep_sleep`=1 and mode field 0, 1 or 2 enters power-down: both clock enables 0, both power enables 1, `pin_tristate`=0.
- R5: In power-down, `usb_wake` or `gpio_grp_irq` returns to running on the next cycle. `wdt_irq` does so only when the watchdog-oscillator bit (bit 5) is 1. `irq_any` has no effect.
- R6: In power-down, `bod_rst` with the brown-out wake bit (bit 4) set, or `wdt_rst` with bit 5 set, starts the reset sequence. Here `sys_rst_req`=1 and both clock and both power enables are 1 for `RST_CYCLES` cycles, then the block returns to running. Without the enable bit the source is ignored.
- R7: Deep power-down is left only by a falling edge on `wakeup_pin`. The edge passes two synchroniser flops, so the reset sequence begins in the third cycle after the pin falls. All other wake inputs are ignored in that state.
- R8: The reset sequence clears control register bits [5:0] to 0 and leaves every retention register unchanged.
- R9: Control register bits [9:8] hold the exit code of the last low-power state left: 0 after power-on reset, 1 for light sleep, 2 for power-down, 3 for deep power-down. The code survives the reset sequence.
- R10: `clk_sel_irc` is 1 for exactly one cycle, the first cycle after power-down or deep power-down is left, and is 0 otherwise.
- R11: Register writes take effect only in the running state. Address 0 reads the control register, addresses 1 to `NUM_GP` read the retention registers, and other addresses read 0.
- R12: A falling edge on `wakeup_pin` outside deep power-down has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state including retention registers |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address (0 control, 1..NUM_GP retention) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from `reg_addr` |
| deep_sleep | input | 1 | Core deep-sleep flag |
| wfi | input | 1 | Wait-for-interrupt strobe from the core |
| wakeup_pin | input | 1 | External wake pin, asynchronous, idles high |
| irq_any | input | 1 | Any enabled interrupt pending |
| usb_wake | input | 1 | USB wake-up interrupt |
| gpio_grp_irq | input | 1 | GPIO group interrupt |
| wdt_irq | input | 1 | Watchdog interrupt |
| wdt_rst | input | 1 | Watchdog reset request |
| bod_rst | input | 1 | Brown-out reset request |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| core_pwr_en | output | 1 | Core power domain enable |
| periph_pwr_en | output | 1 | Peripheral power domain enable |
| pin_tristate | output | 1 | Tri-state all functional pins except the wake pin |
| sys_rst_req | output | 1 | System reset request |
| clk_sel_irc | output | 1 | One-cycle pulse forcing the main clock to the internal RC oscillator |

## Verification
On every cycle the assertions check the entry decision from running: light sleep, power-down, the locked fallback and deep power-down, each judged by the enables seen one cycle after the strobe. They also check that deep power-down can leave only into the reset sequence, that a reset request only follows a stopped core clock, that the retention bank never moves during reset or while the core clock is off, and that the clock-select pulse lasts one cycle. Only the bench's scenarios can show the exact three-cycle latency of the wake pin synchroniser and the length of the reset sequence. The same holds for the qualification of each power-down wake source by its enable bits, the exit code and the cleared control fields read back after each return, and the retention contents read back after deep power-down.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_SLEEP = 3'd1,
      ST_PDN   = 3'd2,
      ST_DPD   = 3'd3,
      ST_RESET = 3'd4
   } lpm_state_e;

   // mode field value that asks for deep power-down
   localparam logic [1:0] MODE_DPD = 2'd3;

   // exit codes kept in the status field
   localparam logic [1:0] EXIT_NONE  = 2'd0;
   localparam logic [1:0] EXIT_SLEEP = 2'd1;
   localparam logic [1:0] EXIT_PDN   = 2'd2;
   localparam logic [1:0] EXIT_DPD   = 2'd3;

   // control register bit positions
   localparam int MODE_LSB   = 0;
   localparam int LOCK_BIT   = 3;
   localparam int BOD_BIT    = 4;
   localparam int WDT_BIT    = 5;
   localparam int STATUS_LSB = 8;

   typedef struct packed {
      logic [1:0] mode;
      logic       dpd_lock;
      logic       bod_wake_en;
      logic       wdt_osc_on;
   } pctl_t;

endpackage

// File: rtl/lpm_wake_sync.sv
module lpm_wake_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin,
   output logic fall
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lpm_wake_sync: STAGES must be at least 2");
   end

   // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
   logic [STAGES:0] chain;

   for (genvar s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) chain[s] <= 1'b1;
            else        chain[s] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) chain[s] <= 1'b1;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign fall = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
   import lpm_pkg::*;
#(
   parameter int RST_CYCLES = 4
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       wfi,
   input  logic       deep_sleep,
   input  pctl_t      cfg,
   input  logic       irq_any,
   input  logic       usb_wake,
   input  logic       gpio_grp_irq,
   input  logic       wdt_irq,
   input  logic       wdt_rst,
   input  logic       bod_rst,
   input  logic       wake_fall,
   output lpm_state_e state_q,
   output logic       exit_vld,
   output logic [1:0] exit_code,
   output logic       clk_irc_q
);

   localparam int CW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);
   localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

   lpm_state_e    state_d;
   logic [CW-1:0] cnt_q;
   logic          pdn_rst_wake;
   logic          pdn_irq_wake;

   assign pdn_rst_wake = (bod_rst & cfg.bod_wake_en) | (wdt_rst & cfg.wdt_osc_on);
   assign pdn_irq_wake = usb_wake | gpio_grp_irq | (wdt_irq & cfg.wdt_osc_on);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN: begin
            if (wfi) begin
               if (!deep_sleep)                                   state_d = ST_SLEEP;
               else if (cfg.mode == MODE_DPD && !cfg.dpd_lock)   state_d = ST_DPD;
               else                                               state_d = ST_PDN;
            end
         end
         ST_SLEEP: if (irq_any)        state_d = ST_RUN;
         ST_PDN: begin
            if (pdn_rst_wake)          state_d = ST_RESET;
            else if (pdn_irq_wake)     state_d = ST_RUN;
         end
         ST_DPD:   if (wake_fall)      state_d = ST_RESET;
         ST_RESET: if (cnt_q == CNT_LAST) state_d = ST_RUN;
         default:                      state_d = ST_RUN;
      endcase
   end

   always_comb begin
      exit_vld  = 1'b0;
      exit_code = EXIT_NONE;
      if (state_d != state_q) begin
         unique case (state_q)
            ST_SLEEP: begin exit_vld = 1'b1; exit_code = EXIT_SLEEP; end
            ST_PDN:   begin exit_vld = 1'b1; exit_code = EXIT_PDN;   end
            ST_DPD:   begin exit_vld = 1'b1; exit_code = EXIT_DPD;   end
            default:  begin exit_vld = 1'b0; exit_code = EXIT_NONE;  end
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q   <= ST_RUN;
         cnt_q     <= '0;
         clk_irc_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         cnt_q     <= (state_q == ST_RESET) ? cnt_q + 1'b1 : '0;
         clk_irc_q <= exit_vld && (state_q == ST_PDN || state_q == ST_DPD);
      end
   end

endmodule

// File: rtl/lpm_regs.sv
module lpm_regs
   import lpm_pkg::*;
#(
   parameter int DW     = 32,
   parameter int NUM_GP = 4,
   parameter int AW     = 3
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               we,
   input  logic [AW-1:0]      addr,
   input  logic [DW-1:0]      wdata,
   input  logic               wr_ok,
   input  logic               sys_rst,
   input  logic               exit_vld,
   input  logic [1:0]         exit_code,
   output logic [DW-1:0]      rdata,
   output pctl_t              cfg,
   output logic [NUM_GP*DW-1:0] gp_flat
);

   if (DW < STATUS_LSB + 2) begin : g_bad_dw
      $error("lpm_regs: DW too small for the status field");
   end

   logic       wr_pctl;
   logic [1:0] status_q;

   assign wr_pctl = we && wr_ok && (addr == '0);

   // control fields: cleared by power-on and by the reset sequence
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cfg <= '0;
      end else if (sys_rst) begin
         cfg <= '0;
      end else if (wr_pctl) begin
         cfg.mode        <= wdata[MODE_LSB +: 2];
         cfg.dpd_lock    <= wdata[LOCK_BIT];
         cfg.bod_wake_en <= wdata[BOD_BIT];
         cfg.wdt_osc_on  <= wdata[WDT_BIT];
      end
   end

   // exit code: only power-on clears it
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        status_q <= EXIT_NONE;
      else if (exit_vld) status_q <= exit_code;
   end

   // retention bank: only power-on clears it
   for (genvar g = 0; g < NUM_GP; g++) begin : g_ret
      logic [DW-1:0] val_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            val_q <= '0;
         else if (we && wr_ok && addr == AW'(g + 1))
            val_q <= wdata;
      end
      assign gp_flat[g*DW +: DW] = val_q;
   end

   always_comb begin
      rdata = '0;
      if (addr == '0) begin
         rdata[MODE_LSB +: 2]   = cfg.mode;
         rdata[LOCK_BIT]        = cfg.dpd_lock;
         rdata[BOD_BIT]         = cfg.bod_wake_en;
         rdata[WDT_BIT]         = cfg.wdt_osc_on;
         rdata[STATUS_LSB +: 2] = status_q;
      end else begin
         for (int i = 0; i < NUM_GP; i++) begin
            if (addr == AW'(i + 1)) rdata = gp_flat[i*DW +: DW];
         end
      end
   end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int DW          = 32,
   parameter int NUM_GP      = 4,
   parameter int RST_CYCLES  = 4,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(NUM_GP + 1)
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          reg_we,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          deep_sleep,
   input  logic          wfi,
   input  logic          wakeup_pin,
   input  logic          irq_any,
   input  logic          usb_wake,
   input  logic          gpio_grp_irq,
   input  logic          wdt_irq,
   input  logic          wdt_rst,
   input  logic          bod_rst,
   output logic          core_clk_en,
   output logic          periph_clk_en,
   output logic          core_pwr_en,
   output logic          periph_pwr_en,
   output logic          pin_tristate,
   output logic          sys_rst_req,
   output logic          clk_sel_irc
);

   if (NUM_GP < 1) begin : g_bad_gp
      $error("lpm_ctrl: NUM_GP must be at least 1");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("lpm_ctrl: RST_CYCLES must be at least 1");
   end

   lpm_state_e            state_q;
   pctl_t                 cfg;
   logic                  wake_fall;
   logic                  exit_vld;
   logic [1:0]            exit_code;
   logic [NUM_GP*DW-1:0]  gp_flat;
   logic [1:0]            cur_mode;
   logic                  cur_lock;

   assign cur_mode = cfg.mode;
   assign cur_lock = cfg.dpd_lock;

   lpm_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .pin   (wakeup_pin),
      .fall  (wake_fall)
   );

   lpm_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
      .clk          (clk),
      .por_n        (por_n),
      .wfi          (wfi),
      .deep_sleep   (deep_sleep),
      .cfg          (cfg),
      .irq_any      (irq_any),
      .usb_wake     (usb_wake),
      .gpio_grp_irq (gpio_grp_irq),
      .wdt_irq      (wdt_irq),
      .wdt_rst      (wdt_rst),
      .bod_rst      (bod_rst),
      .wake_fall    (wake_fall),
      .state_q      (state_q),
      .exit_vld     (exit_vld),
      .exit_code    (exit_code),
      .clk_irc_q    (clk_sel_irc)
   );

   lpm_regs #(.DW(DW), .NUM_GP(NUM_GP), .AW(AW)) u_regs (
      .clk       (clk),
      .por_n     (por_n),
      .we        (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .wr_ok     (state_q == ST_RUN),
      .sys_rst   (state_q == ST_RESET),
      .exit_vld  (exit_vld),
      .exit_code (exit_code),
      .rdata     (reg_rdata),
      .cfg       (cfg),
      .gp_flat   (gp_flat)
   );

   always_comb begin
      core_clk_en   = 1'b1;
      periph_clk_en = 1'b1;
      core_pwr_en   = 1'b1;
      periph_pwr_en = 1'b1;
      pin_tristate  = 1'b0;
      sys_rst_req   = 1'b0;
      unique case (state_q)
         ST_SLEEP: core_clk_en = 1'b0;
         ST_PDN: begin
            core_clk_en   = 1'b0;
            periph_clk_en = 1'b0;
         end
         ST_DPD: begin
            core_clk_en   = 1'b0;
            periph_clk_en = 1'b0;
            core_pwr_en   = 1'b0;
            periph_pwr_en = 1'b0;
            pin_tristate  = 1'b1;
         end
         ST_RESET: sys_rst_req = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
   parameter int GPW = 128
) (
   input logic           clk,
   input logic           por_n,
   input logic           wfi,
   input logic           deep_sleep,
   input logic [1:0]     mode,
   input logic           lock,
   input logic [GPW-1:0] gp_flat,
   input logic           core_clk_en,
   input logic           periph_clk_en,
   input logic           core_pwr_en,
   input logic           periph_pwr_en,
   input logic           pin_tristate,
   input logic           sys_rst_req,
   input logic           clk_sel_irc
);

   logic running;
   assign running = core_clk_en && !sys_rst_req;

   p_sleep_entry_r1: assert property (@(posedge clk) disable iff (!por_n)
      running && wfi && !deep_sleep |=>
         !core_clk_en && periph_clk_en && core_pwr_en && periph_pwr_en && !pin_tristate);

   p_dpd_entry_r2: assert property (@(posedge clk) disable iff (!por_n)
      running && wfi && deep_sleep && mode == 2'd3 && !lock |=>
         pin_tristate && !core_clk_en && !periph_clk_en && !core_pwr_en && !periph_pwr_en);

   p_lock_fallback_r3: assert property (@(posedge clk) disable iff (!por_n)
      running && wfi && deep_sleep && lock |=>
         !pin_tristate && core_pwr_en && periph_pwr_en && !periph_clk_en);

   p_pdn_entry_r4: assert property (@(posedge clk) disable iff (!por_n)
      running && wfi && deep_sleep && mode != 2'd3 |=>
         !pin_tristate && core_pwr_en && !core_clk_en && !periph_clk_en);

   p_rst_from_lowpower_r6: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sys_rst_req) |-> $past(!core_clk_en));

   p_dpd_exit_r7: assert property (@(posedge clk) disable iff (!por_n)
      pin_tristate |=> pin_tristate || sys_rst_req);

   p_retain_r8: assert property (@(posedge clk) disable iff (!por_n)
      sys_rst_req |=> $stable(gp_flat));

   p_irc_pulse_r10: assert property (@(posedge clk) disable iff (!por_n)
      clk_sel_irc |=> !clk_sel_irc);

   p_no_write_r11: assert property (@(posedge clk) disable iff (!por_n)
      !core_clk_en |=> $stable(gp_flat));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.GPW(NUM_GP * DW)) u_chk (
   .clk           (clk),
   .por_n         (por_n),
   .wfi           (wfi),
   .deep_sleep    (deep_sleep),
   .mode          (cur_mode),
   .lock          (cur_lock),
   .gp_flat       (gp_flat),
   .core_clk_en   (core_clk_en),
   .periph_clk_en (periph_clk_en),
   .core_pwr_en   (core_pwr_en),
   .periph_pwr_en (periph_pwr_en),
   .pin_tristate  (pin_tristate),
   .sys_rst_req   (sys_rst_req),
   .clk_sel_irc   (clk_sel_irc)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

   localparam int DW = 32;
   localparam int NG = 4;
   localparam int RC = 4;
   localparam int AW = 3;

   // expected state codes used by the bench
   localparam int E_RUN = 0, E_SLEEP = 1, E_PDN = 2, E_DPD = 3, E_RST = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          por_n;
   logic          reg_we;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata;
   logic [DW-1:0] reg_rdata;
   logic deep_sleep, wfi, wakeup_pin, irq_any, usb_wake, gpio_grp_irq;
   logic wdt_irq, wdt_rst, bod_rst;
   logic core_clk_en, periph_clk_en, core_pwr_en, periph_pwr_en;
   logic pin_tristate, sys_rst_req, clk_sel_irc;

   lpm_ctrl #(.DW(DW), .NUM_GP(NG), .RST_CYCLES(RC), .SYNC_STAGES(2)) u_lpm_ctrl (
      .clk(clk), .por_n(por_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .deep_sleep(deep_sleep),
      .wfi(wfi), .wakeup_pin(wakeup_pin), .irq_any(irq_any), .usb_wake(usb_wake),
      .gpio_grp_irq(gpio_grp_irq), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst),
      .bod_rst(bod_rst), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
      .core_pwr_en(core_pwr_en), .periph_pwr_en(periph_pwr_en),
      .pin_tristate(pin_tristate), .sys_rst_req(sys_rst_req), .clk_sel_irc(clk_sel_irc)
   );

   wire [5:0] outs = {core_clk_en, periph_clk_en, core_pwr_en, periph_pwr_en,
                      pin_tristate, sys_rst_req};

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   function automatic logic [5:0] exp_outs(int st);
      case (st)
         E_SLEEP: return 6'b011100;
         E_PDN:   return 6'b001100;
         E_DPD:   return 6'b000010;
         E_RST:   return 6'b111101;
         default: return 6'b111100;
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic enter(logic ds);
      deep_sleep = ds; wfi = 1'b1;
      step();
      wfi = 1'b0;
   endtask

   function automatic logic [DW-1:0] gp_val(int i);
      return 32'hA500_0000 + 32'(i * 17);
   endfunction

   // deep power-down exit through the wake pin, checks latency and length
   task automatic dpd_wake();
      wakeup_pin = 1'b0;
      step();
      chk("R7 sync stage 1", 32'(outs), 32'(exp_outs(E_DPD)));
      step();
      chk("R7 sync stage 2", 32'(outs), 32'(exp_outs(E_DPD)));
      step();
      chk("R7 reset begins", 32'(outs), 32'(exp_outs(E_RST)));
      chk("R10 pulse after deep exit", 32'(clk_sel_irc), 32'd1);
      repeat (RC - 1) step();
      chk("R6 reset last cycle", 32'(outs), 32'(exp_outs(E_RST)));
      step();
      chk("R6 reset done", 32'(outs), 32'(exp_outs(E_RUN)));
      wakeup_pin = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog all requirements actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rv;
      por_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      deep_sleep = 1'b0; wfi = 1'b0; wakeup_pin = 1'b1; irq_any = 1'b0;
      usb_wake = 1'b0; gpio_grp_irq = 1'b0; wdt_irq = 1'b0; wdt_rst = 1'b0;
      bod_rst = 1'b0;
      repeat (3) step();
      por_n = 1'b1;
      step();

      // reset state
      chk("R9 reset outputs", 32'(outs), 32'(exp_outs(E_RUN)));
      chk("R10 reset pulse low", 32'(clk_sel_irc), 32'd0);
      rd(0, rv);
      chk("R9 status after power-on", rv, 32'd0);

      // R11 address map
      for (int i = 0; i < NG; i++) wr(AW'(i + 1), gp_val(i));
      for (int i = 0; i < NG; i++) begin
         rd(AW'(i + 1), rv);
         chk("R11 retention readback", rv, gp_val(i));
      end
      for (int a = NG + 1; a < (1 << AW); a++) begin
         rd(AW'(a), rv);
         chk("R11 unused address", rv, 32'd0);
      end

      // R12 wake pin edge while running
      wakeup_pin = 1'b0;
      repeat (4) step();
      chk("R12 pin fall while running", 32'(outs), 32'(exp_outs(E_RUN)));
      wakeup_pin = 1'b1;
      repeat (3) step();

      // entry matrix: deep flag x mode x lock
      for (int ds = 0; ds < 2; ds++) begin
         for (int md = 0; md < 4; md++) begin
            for (int lk = 0; lk < 2; lk++) begin
               logic [DW-1:0] cfgw;
               int st;
               string tag;
               cfgw = 32'(md) | (32'(lk) << 3);
               wr(0, cfgw);
               enter(logic'(ds));
               st  = (ds == 0) ? E_SLEEP : ((md == 3 && lk == 0) ? E_DPD : E_PDN);
               tag = (st == E_SLEEP) ? "R1 entry" : (st == E_DPD) ? "R2 entry" :
                     (md == 3) ? "R3 locked fallback" : "R4 entry";
               chk(tag, 32'(outs), 32'(exp_outs(st)));
               if (st == E_SLEEP) begin
                  irq_any = 1'b1; step(); irq_any = 1'b0;
                  chk("R1 wake", 32'(outs), 32'(exp_outs(E_RUN)));
                  chk("R10 no pulse after sleep", 32'(clk_sel_irc), 32'd0);
                  rd(0, rv);
                  chk("R9 status sleep", rv, cfgw | (32'd1 << 8));
               end else if (st == E_PDN) begin
                  gpio_grp_irq = 1'b1; step(); gpio_grp_irq = 1'b0;
                  chk("R5 gpio wake", 32'(outs), 32'(exp_outs(E_RUN)));
                  chk("R10 pulse after power-down", 32'(clk_sel_irc), 32'd1);
                  step();
                  chk("R10 pulse one cycle", 32'(clk_sel_irc), 32'd0);
                  rd(0, rv);
                  chk("R9 status power-down", rv, cfgw | (32'd2 << 8));
               end else begin
                  irq_any = 1'b1; usb_wake = 1'b1; gpio_grp_irq = 1'b1;
                  wdt_irq = 1'b1; wdt_rst = 1'b1; bod_rst = 1'b1;
                  step();
                  irq_any = 1'b0; usb_wake = 1'b0; gpio_grp_irq = 1'b0;
                  wdt_irq = 1'b0; wdt_rst = 1'b0; bod_rst = 1'b0;
                  chk("R7 other sources ignored", 32'(outs), 32'(exp_outs(E_DPD)));
                  dpd_wake();
                  rd(0, rv);
                  chk("R8 R9 control cleared, status deep", rv, 32'd3 << 8);
                  for (int i = 0; i < NG; i++) begin
                     rd(AW'(i + 1), rv);
                     chk("R8 retention kept", rv, gp_val(i));
                  end
               end
            end
         end
      end

      // power-down wake source sweep over both enable bits
      for (int en = 0; en < 4; en++) begin
         for (int src = 0; src < 6; src++) begin
            logic bod_en, wdt_on;
            int   st;
            bod_en = en[0]; wdt_on = en[1];
            wr(0, 32'd2 | (32'(bod_en) << 4) | (32'(wdt_on) << 5));
            enter(1'b1);
            chk("R4 sweep entry", 32'(outs), 32'(exp_outs(E_PDN)));
            case (src)
               0: irq_any = 1'b1;
               1: usb_wake = 1'b1;
               2: gpio_grp_irq = 1'b1;
               3: wdt_irq = 1'b1;
               4: wdt_rst = 1'b1;
               default: bod_rst = 1'b1;
            endcase
            step();
            irq_any = 1'b0; usb_wake = 1'b0; gpio_grp_irq = 1'b0;
            wdt_irq = 1'b0; wdt_rst = 1'b0; bod_rst = 1'b0;
            case (src)
               0: st = E_PDN;
               1, 2: st = E_RUN;
               3: st = wdt_on ? E_RUN : E_PDN;
               4: st = wdt_on ? E_RST : E_PDN;
               default: st = bod_en ? E_RST : E_PDN;
            endcase
            chk((src >= 4) ? "R6 reset-type wake" : "R5 interrupt wake",
                32'(outs), 32'(exp_outs(st)));
            if (st == E_PDN) begin
               gpio_grp_irq = 1'b1; step(); gpio_grp_irq = 1'b0;
            end else if (st == E_RST) begin
               repeat (RC) step();
               chk("R6 back to running", 32'(outs), 32'(exp_outs(E_RUN)));
               rd(0, rv);
               chk("R8 R9 after power-down reset", rv, 32'd2 << 8);
            end
         end
      end

      // R11 writes ignored outside running
      wr(1, 32'h0000_1111);
      enter(1'b0);
      reg_we = 1'b1; reg_addr = 1; reg_wdata = 32'h0000_2222;
      step();
      reg_we = 1'b0;
      irq_any = 1'b1; step(); irq_any = 1'b0;
      rd(1, rv);
      chk("R11 write during sleep ignored", rv, 32'h0000_1111);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule